// File: doc/BRIEF.md
# DMA Interrupt Status and Clear Unit

This unit gathers per-channel completion and failure events from a multi-channel DMA engine and holds them in status bits. Completion means that all data for the current descriptor has reached its destination. Failure means that a bus error occurred. Each channel keeps one completion bit and one failure bit. Enable bits come in from the channels' own control and configuration logic and gate those bits into a masked view. The masked view then drives the interrupt requests.

The status bits of each channel are held by a small state machine with four states:
- `CH_IDLE`: nothing is pending.
- `CH_TC`: only completion is pending.
- `CH_ERR`: only failure is pending.
- `CH_BOTH`: both are pending.

The transitions are named as follows:
- *raise*: an event arrives for a kind that is clear.
- *hold*: nothing happens to a kind, or a clear arrives in the same cycle as a new event.
- *drop*: a clear arrives and no new event arrives for that kind.

Software reaches the unit through a simple register port with valid, write, address and data signals. It can read the raw, masked and combined views. It retires requests one at a time by writing ones to one of two clear registers. The unit drives three registered requests at the same time: any-kind, completion-only and failure-only. It also drives the lowest-numbered channel with a pending masked request, because channel 0 has the highest priority.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, every status bit is 0, every register read returns 0, and `irq_any`, `irq_tc`, `irq_err` and `pend_valid` are 0.
- R2: A high `tc_event[i]` (or `err_event[i]`) at a clock edge sets the raw completion (or failure) bit of channel i at that edge, whatever its enable bit is.
- R3: The masked completion bit equals raw completion AND `tc_enable`. The masked failure bit equals raw failure AND `err_enable`. Clearing an enable hides a request but does not erase the raw bit.
- R4: The combined status bit of a channel is the OR of its masked completion and masked failure bits.
- R5: A write of data D to the completion-clear register clears exactly the completion bits where D is 1, and the failure-clear register does the same for failure bits. A zero bit leaves its status unchanged, and neither clear register touches the other kind.
- R6: When a new event and a clear for the same status bit arrive in the same cycle, the bit stays set.
- R7: `irq_any`, `irq_tc` and `irq_err` are registered. They equal the OR of the combined, masked completion and masked failure bits as those bits stood one clock earlier.
- R8: `pend_valid` is high and `pend_chan` holds the lowest-numbered channel whose combined bit was set one clock earlier. When no combined bit was set, `pend_valid` is 0.
- R9: The register map, by `reg_addr`, is:
  - 0: combined status
  - 1: masked completion
  - 2: masked failure
  - 3: raw completion
  - 4: raw failure
  - 5: completion clear
  - 6: failure clear
  
  A read (`reg_valid`=1, `reg_write`=0) returns the addressed view in bit i for channel i. Reads of 5, 6 and 7 return 0, and writes to addresses 0 to 4 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_event | input | N_CH | Per-channel completion event pulses |
| err_event | input | N_CH | Per-channel bus error event pulses |
| tc_enable | input | N_CH | Per-channel completion request enables |
| err_enable | input | N_CH | Per-channel failure request enables |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Register selector |
| reg_wdata | input | N_CH | Write data, one bit per channel |
| reg_rdata | output | N_CH | Read data, combinational from the address |
| irq_any | output | 1 | Registered request: any masked bit pending |
| irq_tc | output | 1 | Registered request: masked completion pending |
| irq_err | output | 1 | Registered request: masked failure pending |
| pend_chan | output | CH_W | Lowest-numbered channel with a pending combined bit |
| pend_valid | output | 1 | `pend_chan` is meaningful |

## Verification
The bench builds the unit with four channels rather than the default two. This lets a selective clear leave a non-contiguous set of bits behind. It also lets the priority output be seen to step past several lower channels, and lets masked-off and unmasked channels sit side by side in one register. The event/clear collision runs with another channel being cleared in the same write, so the bench checks that the winning event does not shield its neighbours.

// File: rtl/isc_pkg.sv
package isc_pkg;

    // Per-channel pending state: bit 0 = completion, bit 1 = failure
    typedef enum logic [1:0] {
        CH_IDLE = 2'b00,
        CH_TC   = 2'b01,
        CH_ERR  = 2'b10,
        CH_BOTH = 2'b11
    } ch_state_e;

    localparam int REG_AW = 3;

    localparam logic [REG_AW-1:0] OFS_COMB    = 3'd0;
    localparam logic [REG_AW-1:0] OFS_MTC     = 3'd1;
    localparam logic [REG_AW-1:0] OFS_MERR    = 3'd2;
    localparam logic [REG_AW-1:0] OFS_RTC     = 3'd3;
    localparam logic [REG_AW-1:0] OFS_RERR    = 3'd4;
    localparam logic [REG_AW-1:0] OFS_CLR_TC  = 3'd5;
    localparam logic [REG_AW-1:0] OFS_CLR_ERR = 3'd6;

    function automatic ch_state_e pack_state(input logic tc, input logic err);
        return ch_state_e'({err, tc});
    endfunction

endpackage

// File: rtl/isc_chan.sv
module isc_chan
    import isc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tc_ev,
    input  logic err_ev,
    input  logic tc_clr,
    input  logic err_clr,
    output logic raw_tc,
    output logic raw_err
);

    ch_state_e state_q, state_d;
    logic keep_tc, keep_err;

    // A new event always wins against a clear of the same kind
    assign keep_tc  = tc_ev  | ~tc_clr;
    assign keep_err = err_ev | ~err_clr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: state_d = pack_state(tc_ev, err_ev);
            CH_TC:   state_d = pack_state(keep_tc, err_ev);
            CH_ERR:  state_d = pack_state(tc_ev, keep_err);
            CH_BOTH: state_d = pack_state(keep_tc, keep_err);
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        raw_tc  = (state_q == CH_TC)  || (state_q == CH_BOTH);
        raw_err = (state_q == CH_ERR) || (state_q == CH_BOTH);
    end

    p_event_wins_tc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tc_ev |=> raw_tc);
    p_event_wins_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_ev |=> raw_err);
    p_clear_tc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_clr && !tc_ev) |=> !raw_tc);
    p_hold_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_ev && !err_clr) |=> $stable(raw_err));

endmodule

// File: rtl/isc_regport.sv
module isc_regport
    import isc_pkg::*;
#(
    parameter int N_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [N_CH-1:0]   reg_wdata,
    input  logic [N_CH-1:0]   raw_tc,
    input  logic [N_CH-1:0]   raw_err,
    input  logic [N_CH-1:0]   msk_tc,
    input  logic [N_CH-1:0]   msk_err,
    input  logic [N_CH-1:0]   comb,
    output logic [N_CH-1:0]   reg_rdata,
    output logic [N_CH-1:0]   tc_clr,
    output logic [N_CH-1:0]   err_clr
);

    logic wr_go, rd_go;

    assign wr_go = reg_valid &&  reg_write;
    assign rd_go = reg_valid && !reg_write;

    always_comb begin
        tc_clr  = '0;
        err_clr = '0;
        if (wr_go && reg_addr == OFS_CLR_TC)  tc_clr  = reg_wdata;
        if (wr_go && reg_addr == OFS_CLR_ERR) err_clr = reg_wdata;
    end

    always_comb begin
        reg_rdata = '0;
        if (rd_go) begin
            unique case (reg_addr)
                OFS_COMB: reg_rdata = comb;
                OFS_MTC:  reg_rdata = msk_tc;
                OFS_MERR: reg_rdata = msk_err;
                OFS_RTC:  reg_rdata = raw_tc;
                OFS_RERR: reg_rdata = raw_err;
                default:  reg_rdata = '0;
            endcase
        end
    end

    p_clr_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !((|tc_clr) && (|err_clr)));
    p_clr_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_CLR_TC || reg_addr == OFS_CLR_ERR) |-> (reg_rdata == '0));

endmodule

// File: rtl/isc_irq_out.sv
module isc_irq_out #(
    parameter int N_CH = 2,
    parameter int CH_W = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] msk_tc,
    input  logic [N_CH-1:0] msk_err,
    input  logic [N_CH-1:0] comb,
    output logic            irq_any,
    output logic            irq_tc,
    output logic            irq_err,
    output logic [CH_W-1:0] pend_chan,
    output logic            pend_valid
);

    localparam logic [N_CH-1:0] CH_ONE = N_CH'(1);

    logic [CH_W-1:0] sel_d;
    logic            hit_d;

    // Channel 0 wins: scan from the top so that lower indices overwrite
    always_comb begin
        sel_d = '0;
        hit_d = 1'b0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (comb[i]) begin
                sel_d = CH_W'(i);
                hit_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_any    <= 1'b0;
            irq_tc     <= 1'b0;
            irq_err    <= 1'b0;
            pend_chan  <= '0;
            pend_valid <= 1'b0;
        end else begin
            irq_any    <= |comb;
            irq_tc     <= |msk_tc;
            irq_err    <= |msk_err;
            pend_chan  <= sel_d;
            pend_valid <= hit_d;
        end
    end

    p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_any == $past(|comb)));
    p_split_under_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_tc || irq_err) |-> irq_any);
    p_pend_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> ((($past(comb) >> pend_chan) & CH_ONE) != '0));

endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import isc_pkg::*;
#(
    parameter int N_CH = 2,
    localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_CH-1:0]   tc_event,
    input  logic [N_CH-1:0]   err_event,
    input  logic [N_CH-1:0]   tc_enable,
    input  logic [N_CH-1:0]   err_enable,
    input  logic              reg_valid,
    input  logic              reg_write,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [N_CH-1:0]   reg_wdata,
    output logic [N_CH-1:0]   reg_rdata,
    output logic              irq_any,
    output logic              irq_tc,
    output logic              irq_err,
    output logic [CH_W-1:0]   pend_chan,
    output logic              pend_valid
);

    logic [N_CH-1:0] raw_tc, raw_err, msk_tc, msk_err, comb;
    logic [N_CH-1:0] tc_clr, err_clr;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        isc_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .tc_ev   (tc_event[g]),
            .err_ev  (err_event[g]),
            .tc_clr  (tc_clr[g]),
            .err_clr (err_clr[g]),
            .raw_tc  (raw_tc[g]),
            .raw_err (raw_err[g])
        );
    end

    assign msk_tc  = raw_tc  & tc_enable;
    assign msk_err = raw_err & err_enable;
    assign comb    = msk_tc  | msk_err;

    isc_regport #(.N_CH(N_CH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_valid (reg_valid),
        .reg_write (reg_write),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .raw_tc    (raw_tc),
        .raw_err   (raw_err),
        .msk_tc    (msk_tc),
        .msk_err   (msk_err),
        .comb      (comb),
        .reg_rdata (reg_rdata),
        .tc_clr    (tc_clr),
        .err_clr   (err_clr)
    );

    isc_irq_out #(.N_CH(N_CH), .CH_W(CH_W)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .msk_tc     (msk_tc),
        .msk_err    (msk_err),
        .comb       (comb),
        .irq_any    (irq_any),
        .irq_tc     (irq_tc),
        .irq_err    (irq_err),
        .pend_chan  (pend_chan),
        .pend_valid (pend_valid)
    );

    p_mask_hides_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && reg_addr == OFS_MTC) |-> ((reg_rdata & ~tc_enable) == '0));

endmodule

// File: tb/sim_dma_irq_status.sv
`timescale 1ns/1ps
module sim_dma_irq_status;
    localparam int NC = 4;
    localparam int CW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC-1:0] tc_event = '0, err_event = '0, tc_enable = '0, err_enable = '0;
    logic reg_valid = 1'b0, reg_write = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [NC-1:0] reg_wdata = '0;
    logic [NC-1:0] reg_rdata;
    logic irq_any, irq_tc, irq_err, pend_valid;
    logic [CW-1:0] pend_chan;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dma_irq_status #(.N_CH(NC)) u0 (
        .clk(clk), .rst_n(rst_n),
        .tc_event(tc_event), .err_event(err_event),
        .tc_enable(tc_enable), .err_enable(err_enable),
        .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_any(irq_any), .irq_tc(irq_tc), .irq_err(irq_err),
        .pend_chan(pend_chan), .pend_valid(pend_valid)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [NC-1:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        #1 d = reg_rdata;
        reg_valid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [NC-1:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_valid = 1'b0; reg_write = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input logic [NC-1:0] t, input logic [NC-1:0] e);
        @(negedge clk);
        tc_event = t; err_event = e;
        @(posedge clk); #1;
        tc_event = '0; err_event = '0;
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        logic [NC-1:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reset read", int'(d), 0);
        end
        check("R1 irq_any", int'(irq_any), 0);
        check("R1 irq_tc", int'(irq_tc), 0);
        check("R1 irq_err", int'(irq_err), 0);
        check("R1 pend_valid", int'(pend_valid), 0);
    endtask

    task automatic t_tc_mask();
        logic [NC-1:0] d;
        tc_enable = 4'b0101; err_enable = 4'b0000;
        pulse(4'b0011, 4'b0000);
        check("R7 irq_tc lags one cycle", int'(irq_tc), 0);
        rd(3'd3, d); check("R2 raw tc", int'(d), 3);
        rd(3'd1, d); check("R3 masked tc", int'(d), 1);
        rd(3'd0, d); check("R4 combined", int'(d), 1);
        settle();
        check("R7 irq_tc", int'(irq_tc), 1);
        check("R7 irq_any", int'(irq_any), 1);
        check("R7 irq_err", int'(irq_err), 0);
        check("R8 pend_valid", int'(pend_valid), 1);
        check("R8 pend_chan", int'(pend_chan), 0);
        wr(3'd5, 4'b1111);
        rd(3'd3, d); check("R5 tc cleared", int'(d), 0);
        settle();
        check("R7 irq_any drops", int'(irq_any), 0);
    endtask

    task automatic t_err_sel();
        logic [NC-1:0] d;
        tc_enable = 4'b0100; err_enable = 4'b1111;
        pulse(4'b0100, 4'b1010);
        rd(3'd4, d); check("R2 raw err", int'(d), 4'b1010);
        rd(3'd2, d); check("R3 masked err", int'(d), 4'b1010);
        settle();
        check("R7 irq_err", int'(irq_err), 1);
        wr(3'd6, 4'b0010);
        rd(3'd4, d); check("R5 selective err clear", int'(d), 4'b1000);
        rd(3'd3, d); check("R5 err clear spares tc", int'(d), 4'b0100);
        wr(3'd6, 4'b0000);
        rd(3'd4, d); check("R5 zero write no effect", int'(d), 4'b1000);
        wr(3'd5, 4'b0100);
        rd(3'd3, d); check("R5 tc clear", int'(d), 0);
        rd(3'd4, d); check("R5 tc clear spares err", int'(d), 4'b1000);
        wr(3'd6, 4'b1000);
        rd(3'd4, d); check("R5 err all clear", int'(d), 0);
    endtask

    task automatic t_collision();
        logic [NC-1:0] d;
        tc_enable = 4'b1111;
        pulse(4'b0110, 4'b0000);
        @(negedge clk);
        tc_event = 4'b0010;
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 3'd5; reg_wdata = 4'b0110;
        @(posedge clk); #1;
        tc_event = '0; reg_valid = 1'b0; reg_write = 1'b0; reg_wdata = '0;
        rd(3'd3, d); check("R6 event beats clear", int'(d), 4'b0010);
        wr(3'd5, 4'b1111);
    endtask

    task automatic t_priority();
        logic [NC-1:0] d;
        tc_enable = 4'b1111; err_enable = 4'b1111;
        pulse(4'b0000, 4'b1000);
        settle();
        check("R8 pend_chan 3", int'(pend_chan), 3);
        pulse(4'b0100, 4'b0000);
        settle();
        check("R8 pend_chan 2", int'(pend_chan), 2);
        wr(3'd6, 4'b1000);
        settle();
        check("R8 pend_chan stays 2", int'(pend_chan), 2);
        check("R7 irq_err off", int'(irq_err), 0);
        tc_enable = 4'b1011;
        settle(); settle();
        check("R8 pend_valid masked", int'(pend_valid), 0);
        check("R3 mask hides irq", int'(irq_any), 0);
        rd(3'd3, d); check("R3 raw kept under mask", int'(d), 4'b0100);
        rd(3'd0, d); check("R4 combined masked", int'(d), 0);
        tc_enable = 4'b1111;
        wr(3'd5, 4'b1111);
    endtask

    task automatic t_regmap();
        logic [NC-1:0] d;
        pulse(4'b0001, 4'b0000);
        for (int a = 0; a < 5; a++) wr(3'(a), 4'b0000);
        wr(3'd7, 4'b1111);
        wr(3'd3, 4'b1111);
        rd(3'd3, d); check("R9 read-only writes ignored", int'(d), 1);
        rd(3'd5, d); check("R9 clear reg reads 0", int'(d), 0);
        rd(3'd6, d); check("R9 clear reg reads 0", int'(d), 0);
        rd(3'd7, d); check("R9 unmapped reads 0", int'(d), 0);
        wr(3'd5, 4'b0001);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_tc_mask();
        t_err_sel();
        t_collision();
        t_priority();
        t_regmap();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule